// File: doc/BRIEF.md
# Lane-Parallel Long-Stream Adder

This block adds two very wide unsigned operands plus a carry-in bit. It returns the wide sum and a carry-out bit. The operands are split into equal lanes. Every lane forms its own sum modulo the lane width, along with two flags. The first flag says the lane produced a carry. The second says the lane sum is all ones, so the lane would pass an incoming carry straight through. The lane flags are then packed into two small integers with one bit per lane. A single add, mask and subtract on those integers tells every lane whether it must add one. No carry ripples across the full width.

The lane width, the lane count and an optional register between the lane stage and the cross-lane stage are parameters. The result is always registered. A valid strobe travels with each operand pair. The output holds its last value until the next result arrives.

Top module: `lsa_adder`

## Requirements
- R1: When `out_vld` is high, {`out_cout`, `out_sum`} equals the full-width unsigned value `in_a + in_b + in_cin` of the accepted operands, taken modulo 2^(LANE_W*LANES+1).
- R2: A result appears exactly 2 clock cycles after its operands are sampled with `in_vld` high, with the default middle register enabled (1 cycle when it is disabled). A new operand pair may be accepted in every cycle, and `out_vld` is high only in cycles that carry such a result.
- R3: While `rst` is high and in the cycle after it, `out_vld`, `out_sum` and `out_cout` are 0.
- R4: A carry-in of 1 propagates through every lane whose lane sum is all ones. For example, `in_a` all ones, `in_b` zero and `in_cin` = 1 give a sum of zero and a carry-out of 1.
- R5: All-ones operands give all ones with a carry-out of 1 when `in_cin` is 1. With `in_cin` at 0 they give all ones except bit 0, again with a carry-out of 1.
- R6: A carry produced inside one lane passes through a run of all-ones lanes above it and stops at the first lane that is not all ones. When the run reaches the top lane, that carry becomes the carry-out.
- R7: When no lane produces a carry and `in_cin` is 0, each lane of the sum equals its lane operands added modulo 2^LANE_W, and the carry-out is 0.
- R8: While `out_vld` is low, `out_sum` and `out_cout` keep the value of the last result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Operand pair and carry-in are valid this cycle |
| in_a | input | LANE_W*LANES | First operand |
| in_b | input | LANE_W*LANES | Second operand |
| in_cin | input | 1 | Carry into lane 0 |
| out_vld | output | 1 | Result valid this cycle |
| out_sum | output | LANE_W*LANES | Wide sum |
| out_cout | output | 1 | Carry out of the top lane |

## Verification
Two carry sources can act on the same lane in the same add. One is a carry generated inside a lane, and the other is a carry that has already passed through a run of all-ones lanes. The top lane can also generate a carry in the same add that delivers a pass-through carry to it. Directed patterns set up these cases. They alternate generating, all-ones and ordinary lanes, with the external carry-in both set and clear. Random operands are biased per lane towards all-ones, zero and single-bit values, so these coincidences keep recurring in back-to-back streams. Every result is judged against a plain full-width addition that the bench computes, and its arrival cycle is checked as well.

// File: rtl/lsa_pkg.sv
package lsa_pkg;

    localparam int unsigned LANE_W_DEF = 64;
    localparam int unsigned LANES_DEF  = 4;

    // Choice of whether the lane stage is registered before cross-lane resolution
    typedef enum logic {
        STAGE_COMB = 1'b0,
        STAGE_REG  = 1'b1
    } stage_e;

    // Per-lane flags produced by the lane stage
    typedef struct packed {
        logic carry;   // lane generated a carry out of its top bit
        logic bubble;  // lane partial sum is all ones
    } lane_flag_t;

    function automatic int unsigned stage_latency(input stage_e st);
        return (st == STAGE_REG) ? 2 : 1;
    endfunction

endpackage

// File: rtl/lsa_lane.sv
module lsa_lane
    import lsa_pkg::*;
#(
    parameter int unsigned LANE_W = LANE_W_DEF
) (
    input  logic [LANE_W-1:0] op_x,
    input  logic [LANE_W-1:0] op_y,
    output logic [LANE_W-1:0] part_sum,
    output lane_flag_t        flag
);
    logic [LANE_W-1:0] gen_v;
    logic [LANE_W-1:0] prop_v;
    logic [LANE_W-1:0] cy_v;

    always_comb begin
        gen_v       = op_x & op_y;
        prop_v      = op_x ^ op_y;
        part_sum    = op_x + op_y;
        // bit i: a carry leaves position i
        cy_v        = gen_v | (prop_v & ~part_sum);
        flag.carry  = cy_v[LANE_W-1];
        flag.bubble = &part_sum;
    end

endmodule

// File: rtl/lsa_resolve.sv
module lsa_resolve #(
    parameter int unsigned LANES = 4
) (
    input  logic [LANES-1:0] lane_cy,
    input  logic [LANES-1:0] lane_bub,
    input  logic             cin,
    output logic [LANES-1:0] lane_inc,
    output logic             cout
);
    logic [LANES-1:0] cy_mask;
    logic [LANES-1:0] run_end;

    generate
        if (LANES == 1) begin : g_single
            assign cy_mask = cin;
        end else begin : g_multi
            assign cy_mask = {lane_cy[LANES-2:0], cin};
        end
    endgenerate

    always_comb begin
        // add carries into the bubble runs; the surviving bits mark run ends
        run_end  = (cy_mask + lane_bub) & ~lane_bub;
        // subtracting fills each run from its entry carry up to its end
        lane_inc = run_end | (run_end - cy_mask);
        cout     = lane_cy[LANES-1] | (lane_bub[LANES-1] & lane_inc[LANES-1]);
    end

endmodule

// File: rtl/lsa_incr.sv
module lsa_incr #(
    parameter int unsigned LANE_W = 64,
    parameter int unsigned LANES  = 4
) (
    input  logic [LANE_W*LANES-1:0] part_sum,
    input  logic [LANES-1:0]        lane_inc,
    output logic [LANE_W*LANES-1:0] sum
);
    generate
        for (genvar k = 0; k < LANES; k++) begin : g_lane
            assign sum[k*LANE_W +: LANE_W] =
                part_sum[k*LANE_W +: LANE_W] + {{(LANE_W-1){1'b0}}, lane_inc[k]};
        end
    endgenerate

endmodule

// File: rtl/lsa_adder.sv
module lsa_adder
    import lsa_pkg::*;
#(
    parameter int unsigned LANE_W    = LANE_W_DEF,
    parameter int unsigned LANES     = LANES_DEF,
    parameter stage_e      MID_STAGE = STAGE_REG
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_vld,
    input  logic [LANE_W*LANES-1:0] in_a,
    input  logic [LANE_W*LANES-1:0] in_b,
    input  logic                    in_cin,
    output logic                    out_vld,
    output logic [LANE_W*LANES-1:0] out_sum,
    output logic                    out_cout
);
    localparam int unsigned TOT_W = LANE_W * LANES;

    typedef struct packed {
        logic             vld;
        logic             cin;
        logic [TOT_W-1:0] psum;
        logic [LANES-1:0] cy;
        logic [LANES-1:0] bub;
    } mid_t;

    mid_t             mid_d;
    mid_t             mid_q;
    lane_flag_t       flg [LANES];
    logic [TOT_W-1:0] psum_w;
    logic [LANES-1:0] inc_w;
    logic             cout_w;
    logic [TOT_W-1:0] sum_w;

    // Lane stage
    generate
        for (genvar k = 0; k < LANES; k++) begin : g_lane
            lsa_lane #(.LANE_W(LANE_W)) u_lane (
                .op_x     (in_a[k*LANE_W +: LANE_W]),
                .op_y     (in_b[k*LANE_W +: LANE_W]),
                .part_sum (psum_w[k*LANE_W +: LANE_W]),
                .flag     (flg[k])
            );
            assign mid_d.cy[k]  = flg[k].carry;
            assign mid_d.bub[k] = flg[k].bubble;
        end
    endgenerate

    assign mid_d.vld  = in_vld;
    assign mid_d.cin  = in_cin;
    assign mid_d.psum = psum_w;

    // Optional register between lane stage and cross-lane stage
    generate
        if (MID_STAGE == STAGE_REG) begin : g_mid_reg
            always_ff @(posedge clk) begin
                if (rst) begin
                    mid_q <= '0;
                end else begin
                    mid_q.vld <= mid_d.vld;
                    if (mid_d.vld) begin
                        mid_q.cin  <= mid_d.cin;
                        mid_q.psum <= mid_d.psum;
                        mid_q.cy   <= mid_d.cy;
                        mid_q.bub  <= mid_d.bub;
                    end
                end
            end
        end else begin : g_mid_comb
            assign mid_q = mid_d;
        end
    endgenerate

    // Cross-lane stage
    lsa_resolve #(.LANES(LANES)) u_resolve (
        .lane_cy  (mid_q.cy),
        .lane_bub (mid_q.bub),
        .cin      (mid_q.cin),
        .lane_inc (inc_w),
        .cout     (cout_w)
    );

    lsa_incr #(.LANE_W(LANE_W), .LANES(LANES)) u_incr (
        .part_sum (mid_q.psum),
        .lane_inc (inc_w),
        .sum      (sum_w)
    );

    // Output register
    always_ff @(posedge clk) begin
        if (rst) begin
            out_vld  <= 1'b0;
            out_sum  <= '0;
            out_cout <= 1'b0;
        end else begin
            out_vld <= mid_q.vld;
            if (mid_q.vld) begin
                out_sum  <= sum_w;
                out_cout <= cout_w;
            end
        end
    end

endmodule

// File: rtl/lsa_chk.sv
module lsa_chk #(
    parameter int unsigned LANE_W = 64,
    parameter int unsigned LANES  = 4,
    parameter int unsigned LAT    = 2
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    in_vld,
    input logic [LANE_W*LANES-1:0] in_a,
    input logic [LANE_W*LANES-1:0] in_b,
    input logic                    in_cin,
    input logic                    out_vld,
    input logic [LANE_W*LANES-1:0] out_sum,
    input logic                    out_cout
);
    localparam int unsigned TOT_W = LANE_W * LANES;

    logic             v1, v2;
    logic [TOT_W:0]   r1, r2;
    logic             exp_vld;
    logic [TOT_W:0]   exp_val;

    always_ff @(posedge clk) begin
        if (rst) begin
            v1 <= 1'b0;
            v2 <= 1'b0;
            r1 <= '0;
            r2 <= '0;
        end else begin
            v1 <= in_vld;
            v2 <= v1;
            r1 <= {1'b0, in_a} + {1'b0, in_b} + {{TOT_W{1'b0}}, in_cin};
            r2 <= r1;
        end
    end

    assign exp_vld = (LAT == 2) ? v2 : v1;
    assign exp_val = (LAT == 2) ? r2 : r1;

    AST_SUM_REF: assert property (@(posedge clk) disable iff (rst)
        out_vld |-> ({out_cout, out_sum} == exp_val)); // R1

    AST_VLD_LAT: assert property (@(posedge clk) disable iff (rst)
        out_vld == exp_vld); // R2

    AST_RST_IDLE: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!out_vld && out_sum == '0 && !out_cout)); // R3

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !out_vld |-> ($stable(out_sum) && $stable(out_cout))); // R8

endmodule

bind lsa_adder lsa_chk #(
    .LANE_W (LANE_W),
    .LANES  (LANES),
    .LAT    (lsa_pkg::stage_latency(MID_STAGE))
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .in_vld   (in_vld),
    .in_a     (in_a),
    .in_b     (in_b),
    .in_cin   (in_cin),
    .out_vld  (out_vld),
    .out_sum  (out_sum),
    .out_cout (out_cout)
);

// File: tb/sim_lsa_adder.sv
`timescale 1ns/1ps
module sim_lsa_adder;
    localparam int unsigned W   = 64;
    localparam int unsigned L   = 4;
    localparam int unsigned N   = W * L;
    localparam int unsigned LAT = 2;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_vld = 1'b0;
    logic [N-1:0] in_a = '0;
    logic [N-1:0] in_b = '0;
    logic         in_cin = 1'b0;
    logic         out_vld;
    logic [N-1:0] out_sum;
    logic         out_cout;

    int unsigned n_cmp = 0;
    int unsigned n_bad = 0;
    int unsigned cyc   = 0;

    typedef struct {
        logic [N:0]  val;
        int unsigned due;
        string       req;
    } exp_t;

    exp_t sb[$];

    always #4 clk = ~clk;   // 125 MHz
    always @(posedge clk) cyc++;

    lsa_adder #(.LANE_W(W), .LANES(L)) u0 (
        .clk(clk), .rst(rst), .in_vld(in_vld), .in_a(in_a), .in_b(in_b),
        .in_cin(in_cin), .out_vld(out_vld), .out_sum(out_sum), .out_cout(out_cout)
    );

    task automatic check(input bit ok, input string req, input logic [N:0] act, input logic [N:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [N-1:0] lanes4(input logic [W-1:0] l3, input logic [W-1:0] l2,
                                            input logic [W-1:0] l1, input logic [W-1:0] l0);
        return {l3, l2, l1, l0};
    endfunction

    function automatic logic [N-1:0] rnd_wide();
        logic [N-1:0] v;
        for (int k = 0; k < L; k++) begin
            case ($urandom % 4)
                0: v[k*W +: W] = '1;
                1: v[k*W +: W] = '0;
                2: v[k*W +: W] = {$urandom, $urandom};
                default: v[k*W +: W] = 64'd1 << ($urandom % W);
            endcase
        end
        return v;
    endfunction

    // driver: applies one operand pair for one cycle and queues its expectation
    task automatic drive(input logic [N-1:0] a, input logic [N-1:0] b, input logic c, input string req);
        exp_t e;
        @(negedge clk);
        in_a = a; in_b = b; in_cin = c; in_vld = 1'b1;
        e.val = {1'b0, a} + {1'b0, b} + {{N{1'b0}}, c};
        e.due = cyc + LAT;
        e.req = req;
        sb.push_back(e);
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        in_vld = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    // monitor: pops expectations as results appear
    always @(negedge clk) begin
        if (!rst && out_vld) begin
            if (sb.size() == 0) begin
                check(1'b0, "R2 unexpected out_vld", {out_cout, out_sum}, '0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check({out_cout, out_sum} == e.val, e.req, {out_cout, out_sum}, e.val);
                check(cyc == e.due, "R2 latency", (N+1)'(cyc), (N+1)'(e.due));
            end
        end
    end

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        logic [N:0] held;
        repeat (3) @(negedge clk);
        // R3: outputs idle during reset
        check(!out_vld, "R3 out_vld in reset", (N+1)'(out_vld), '0);
        rst = 1'b0;
        @(negedge clk);
        check(!out_vld && out_sum == '0 && !out_cout, "R3 after reset",
              {out_cout, out_sum}, '0);

        // R5: all-ones operands
        drive('1, '1, 1'b1, "R5 all ones cin=1");
        drive('1, '1, 1'b0, "R5 all ones cin=0");
        // R4: carry-in through every lane
        drive('1, '0, 1'b1, "R4 cin ripples all lanes");
        drive('0, '1, 1'b0, "R4 all bubble no cin");
        // R6: generating lane, bubble, ordinary, bubble
        drive(lanes4('1, 64'h5, '1, 64'h8000_0000_0000_0000),
              lanes4('0, 64'h0, '0, 64'h8000_0000_0000_0000), 1'b0, "R6 alternating bubbles");
        // R6: carry crosses three bubbles into carry-out, cin also set
        drive(lanes4('1, '1, '1, 64'hFFFF_FFFF_FFFF_FFFF),
              lanes4('0, '0, '0, 64'h2), 1'b1, "R6 bubble run to top");
        // R6: top lane generates while a pass-through carry reaches it
        drive(lanes4(64'h8000_0000_0000_0001, '1, 64'h0, 64'h8000_0000_0000_0000),
              lanes4(64'h8000_0000_0000_0000, '0, '1, 64'h8000_0000_0000_0000), 1'b1,
              "R6 top lane carry and arrival");
        // R7: no carries anywhere
        drive(lanes4(64'h1, 64'h7, 64'h10, 64'h3), lanes4(64'h1, 64'h8, 64'h20, 64'h4),
              1'b0, "R7 no lane carries");
        idle(6);
        check(sb.size() == 0, "R2 all results delivered", (N+1)'(sb.size()), '0);

        // R8: outputs hold while idle
        held = {out_cout, out_sum};
        repeat (3) @(negedge clk);
        check(!out_vld && {out_cout, out_sum} == held, "R8 hold while idle",
              {out_cout, out_sum}, held);

        // R1: back-to-back biased random stream
        for (int i = 0; i < 300; i++) begin
            drive(rnd_wide(), rnd_wide(), 1'($urandom % 2), "R1 random");
        end
        idle(6);
        check(sb.size() == 0, "R2 stream drained", (N+1)'(sb.size()), '0);

        // R1: random with gaps between operands
        for (int i = 0; i < 40; i++) begin
            drive(rnd_wide(), rnd_wide(), 1'($urandom % 2), "R1 random gapped");
            idle($urandom % 3);
        end
        idle(6);
        held = {out_cout, out_sum};
        @(negedge clk);
        check({out_cout, out_sum} == held, "R8 hold after stream", {out_cout, out_sum}, held);

        summary();
        $finish;
    end

endmodule